// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a memory-mapped pin controller with four port groups behind one simple register bus. A bus master presents an address with write enable and write data. The read data is returned combinationally for the current address. Output levels and pin directions never take a plain write. Software changes them only through write-one-to-set and write-one-to-clear addresses, so it can touch a single pin without a read-modify-write sequence and without racing other agents.

Two general ports (8 and 24 pins) each have their own level, direction and input registers. An auxiliary port (13 pins) has direction, input, set and clear registers. A mixed port combines three pin groups in one word:
- six bidirectional pins, whose direction lives in the auxiliary port's direction registers;
- input-only pins;
- 24 output-only pins, whose programmed value can be read back.

Every pad input passes through a two-flop synchronizer before any input-state register shows it.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset, every output latch and direction latch is 0. All pad outputs, all output enables and all output-only pins are therefore low, and every pin is an input.
- R2: Each general port has a base address: 0x040 for the 8-pin port and 0x060 for the 24-pin port. Relative to the base, the registers are: +0x0 input state, +0x4 output set, +0x8 output clear, +0xC output state, +0x10 direction set, +0x14 direction clear and +0x18 direction state. Register bit i is pin i, and write-data bits above the port width are ignored.
- R3: A write to an output-set address makes every pin whose data bit is 1 high and leaves pins with a 0 bit unchanged. The pad output reflects the new level from the clock edge that takes the write.
- R4: A write to an output-clear address makes every pin whose data bit is 1 low and leaves pins with a 0 bit unchanged.
- R5: A 1 written to a direction-set bit makes that pin an output, and a 1 written to a direction-clear bit makes it an input. The direction-state register and the pad output-enable (1 = driving) both show the current direction.
- R6: The auxiliary port uses these addresses for its pins at bits 12..0: 0x010 direction set, 0x014 direction clear, 0x018 direction state, 0x01C input state, 0x020 output set and 0x024 output clear.
- R7: Mixed bidirectional pin n (n = 0..5) sits at bit n+25. Its level is set at 0x004, cleared at 0x008 and read back at 0x00C. Its direction is set at 0x010, cleared at 0x014 and read back at 0x018.
- R8: The mixed input state at 0x000 places the synchronized values as follows:
  - bidirectional pins 0..4 at bits 10..14;
  - bidirectional pin 5 at bit 24;
  - input-only pin k at bit k, for k = 0..9 and 15..23.
  Input-only pins 10..14 have no effect on the word, and bits 25..31 read 0.
- R9: Output-only pin k (k = 0..23) is set at bit k of 0x004 and cleared at bit k of 0x008. Address 0x00C returns the programmed latches: output-only pins at bits 0..23 and bidirectional levels at bits 25..30. Pad inputs have no effect on this value, and writes to bits 24 and 31 have no effect.
- R10: A change on a pad input first appears in its input-state register after the second rising clock edge, not the first.
- R11: The set and clear addresses and all unmapped addresses read 0. Writes to read-only or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| g0PadIn | input | G0_W | 8-pin general port pad inputs |
| g0PadOut | output | G0_W | 8-pin general port output levels |
| g0PadOe | output | G0_W | 8-pin general port output enables |
| g1PadIn | input | G1_W | 24-pin general port pad inputs |
| g1PadOut | output | G1_W | 24-pin general port output levels |
| g1PadOe | output | G1_W | 24-pin general port output enables |
| auxPadIn | input | AUX_W | Auxiliary port pad inputs |
| auxPadOut | output | AUX_W | Auxiliary port output levels |
| auxPadOe | output | AUX_W | Auxiliary port output enables |
| mixBidirIn | input | 6 | Mixed bidirectional pad inputs |
| mixBidirOut | output | 6 | Mixed bidirectional output levels |
| mixBidirOe | output | 6 | Mixed bidirectional output enables |
| mixInOnly | input | 24 | Mixed input-only pad inputs |
| mixGpo | output | 24 | Mixed output-only pins |

## Verification
The bench targets the split word of the mixed port in three ways:
- It drives input-only pins 10..14 high while the bidirectional pins are low, and the reverse. A design that left those input-only pins in place of bidirectional pins 0..4, or that placed bidirectional pin 5 next to pin 4, would return a wrong word.
- It writes the bidirectional direction bits through the auxiliary port's direction addresses. A design that decoded them elsewhere would leave those pins undriven.
- It writes bits 24 and 31 of the mixed set register, which must not create latch bits.

Partial set and clear patterns laid over earlier values expose a register that is overwritten instead of updated bit by bit. The bench samples an input one edge and then two edges after a pad change, which catches a synchronizer that is missing a stage or has one too many. Writes to output-state and unmapped addresses, and reads of set addresses, confirm that the decode has no aliasing.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int WORD_W    = 32;
  localparam int BIDIR_N   = 6;
  localparam int BIDIR_LSB = 25;
  localparam int GPO_N     = 24;
  localparam int GPI_N     = 24;

  // register offsets that software decodes
  localparam int OFF_MIX_IN   = 'h000;
  localparam int OFF_MIX_SET  = 'h004;
  localparam int OFF_MIX_CLR  = 'h008;
  localparam int OFF_MIX_OUT  = 'h00C;
  localparam int OFF_AUX_DSET = 'h010;
  localparam int OFF_AUX_DCLR = 'h014;
  localparam int OFF_AUX_DIR  = 'h018;
  localparam int OFF_AUX_IN   = 'h01C;
  localparam int OFF_AUX_SET  = 'h020;
  localparam int OFF_AUX_CLR  = 'h024;
  localparam int BASE_G0      = 'h040;
  localparam int BASE_G1      = 'h060;
  localparam int REL_IN = 'h00, REL_SET = 'h04, REL_CLR = 'h08, REL_OUT = 'h0C;
  localparam int REL_DSET = 'h10, REL_DCLR = 'h14, REL_DIR = 'h18;

  typedef struct packed {
    logic mixOutSet;
    logic mixOutClr;
    logic auxDirSet;
    logic auxDirClr;
    logic auxOutSet;
    logic auxOutClr;
    logic [1:0] genOutSet;
    logic [1:0] genOutClr;
    logic [1:0] genDirSet;
    logic [1:0] genDirClr;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_MIX_IN, RD_MIX_OUT, RD_AUX_DIR, RD_AUX_IN,
    RD_G0_IN, RD_G0_OUT, RD_G0_DIR, RD_G1_IN, RD_G1_OUT, RD_G1_DIR
  } rdSel_e;
endpackage

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         strb,
  output rdSel_e            rdSel
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  localparam int GEN_BASE [2] = '{BASE_G0, BASE_G1};

  always_comb begin
    strb = '0;
    strb.mixOutSet = busWe && hit(busAddr, OFF_MIX_SET);
    strb.mixOutClr = busWe && hit(busAddr, OFF_MIX_CLR);
    strb.auxDirSet = busWe && hit(busAddr, OFF_AUX_DSET);
    strb.auxDirClr = busWe && hit(busAddr, OFF_AUX_DCLR);
    strb.auxOutSet = busWe && hit(busAddr, OFF_AUX_SET);
    strb.auxOutClr = busWe && hit(busAddr, OFF_AUX_CLR);
    for (int p = 0; p < 2; p++) begin
      strb.genOutSet[p] = busWe && hit(busAddr, GEN_BASE[p] + REL_SET);
      strb.genOutClr[p] = busWe && hit(busAddr, GEN_BASE[p] + REL_CLR);
      strb.genDirSet[p] = busWe && hit(busAddr, GEN_BASE[p] + REL_DSET);
      strb.genDirClr[p] = busWe && hit(busAddr, GEN_BASE[p] + REL_DCLR);
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (hit(busAddr, OFF_MIX_IN))               rdSel = RD_MIX_IN;
    else if (hit(busAddr, OFF_MIX_OUT))         rdSel = RD_MIX_OUT;
    else if (hit(busAddr, OFF_AUX_DIR))         rdSel = RD_AUX_DIR;
    else if (hit(busAddr, OFF_AUX_IN))          rdSel = RD_AUX_IN;
    else if (hit(busAddr, BASE_G0 + REL_IN))    rdSel = RD_G0_IN;
    else if (hit(busAddr, BASE_G0 + REL_OUT))   rdSel = RD_G0_OUT;
    else if (hit(busAddr, BASE_G0 + REL_DIR))   rdSel = RD_G0_DIR;
    else if (hit(busAddr, BASE_G1 + REL_IN))    rdSel = RD_G1_IN;
    else if (hit(busAddr, BASE_G1 + REL_OUT))   rdSel = RD_G1_OUT;
    else if (hit(busAddr, BASE_G1 + REL_DIR))   rdSel = RD_G1_DIR;
  end
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         outSet,
  input  logic         outClr,
  input  logic         dirSet,
  input  logic         dirClr,
  input  logic [W-1:0] wrBits,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] outQ,
  output logic [W-1:0] dirQ,
  output logic [W-1:0] inSync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ   <= '0;
      dirQ   <= '0;
      meta   <= '0;
      inSync <= '0;
    end else begin
      if (outSet)      outQ <= outQ | wrBits;
      else if (outClr) outQ <= outQ & ~wrBits;
      if (dirSet)      dirQ <= dirQ | wrBits;
      else if (dirClr) dirQ <= dirQ & ~wrBits;
      meta   <= padIn;
      inSync <= meta;
    end
  end
endmodule

// File: rtl/gpio_sc_datapath.sv
module gpio_sc_datapath
  import gpio_sc_pkg::*;
#(
  parameter int G0_W  = 8,
  parameter int G1_W  = 24,
  parameter int AUX_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strb,
  input  rdSel_e             rdSel,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  input  logic [G0_W-1:0]    g0PadIn,
  output logic [G0_W-1:0]    g0Out,
  output logic [G0_W-1:0]    g0Dir,
  input  logic [G1_W-1:0]    g1PadIn,
  output logic [G1_W-1:0]    g1Out,
  output logic [G1_W-1:0]    g1Dir,
  input  logic [AUX_W-1:0]   auxPadIn,
  output logic [AUX_W-1:0]   auxOut,
  output logic [AUX_W-1:0]   auxDir,
  input  logic [BIDIR_N-1:0] bidirPadIn,
  output logic [BIDIR_N-1:0] bidirOut,
  output logic [BIDIR_N-1:0] bidirDir,
  input  logic [GPI_N-1:0]   gpiPadIn,
  output logic [GPO_N-1:0]   gpoOut
);
  localparam int BIDIR_MSB = BIDIR_LSB + BIDIR_N - 1;

  logic [G0_W-1:0]    g0In;
  logic [G1_W-1:0]    g1In;
  logic [AUX_W-1:0]   auxIn;
  logic [BIDIR_N-1:0] bidirMeta, bidirIn;
  logic [GPI_N-1:0]   gpiMeta, gpiIn;
  logic [BIDIR_N-1:0] bidirBits;

  assign bidirBits = wdata[BIDIR_MSB:BIDIR_LSB];

  gpio_sc_bank #(.W(G0_W)) u_g0 (
    .clk, .rstN,
    .outSet(strb.genOutSet[0]), .outClr(strb.genOutClr[0]),
    .dirSet(strb.genDirSet[0]), .dirClr(strb.genDirClr[0]),
    .wrBits(wdata[G0_W-1:0]), .padIn(g0PadIn),
    .outQ(g0Out), .dirQ(g0Dir), .inSync(g0In));

  gpio_sc_bank #(.W(G1_W)) u_g1 (
    .clk, .rstN,
    .outSet(strb.genOutSet[1]), .outClr(strb.genOutClr[1]),
    .dirSet(strb.genDirSet[1]), .dirClr(strb.genDirClr[1]),
    .wrBits(wdata[G1_W-1:0]), .padIn(g1PadIn),
    .outQ(g1Out), .dirQ(g1Dir), .inSync(g1In));

  gpio_sc_bank #(.W(AUX_W)) u_aux (
    .clk, .rstN,
    .outSet(strb.auxOutSet), .outClr(strb.auxOutClr),
    .dirSet(strb.auxDirSet), .dirClr(strb.auxDirClr),
    .wrBits(wdata[AUX_W-1:0]), .padIn(auxPadIn),
    .outQ(auxOut), .dirQ(auxDir), .inSync(auxIn));

  // mixed port latches; direction strobes are shared with the auxiliary port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpoOut    <= '0;
      bidirOut  <= '0;
      bidirDir  <= '0;
      bidirMeta <= '0;
      bidirIn   <= '0;
      gpiMeta   <= '0;
      gpiIn     <= '0;
    end else begin
      if (strb.mixOutSet) begin
        gpoOut   <= gpoOut | wdata[GPO_N-1:0];
        bidirOut <= bidirOut | bidirBits;
      end else if (strb.mixOutClr) begin
        gpoOut   <= gpoOut & ~wdata[GPO_N-1:0];
        bidirOut <= bidirOut & ~bidirBits;
      end
      if (strb.auxDirSet)      bidirDir <= bidirDir | bidirBits;
      else if (strb.auxDirClr) bidirDir <= bidirDir & ~bidirBits;
      bidirMeta <= bidirPadIn;
      bidirIn   <= bidirMeta;
      gpiMeta   <= gpiPadIn;
      gpiIn     <= gpiMeta;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rdSel)
      RD_MIX_IN: begin
        rdata[9:0]   = gpiIn[9:0];
        rdata[14:10] = bidirIn[4:0];
        rdata[23:15] = gpiIn[23:15];
        rdata[24]    = bidirIn[5];
      end
      RD_MIX_OUT: begin
        rdata[GPO_N-1:0]          = gpoOut;
        rdata[BIDIR_MSB:BIDIR_LSB] = bidirOut;
      end
      RD_AUX_DIR: begin
        rdata[AUX_W-1:0]           = auxDir;
        rdata[BIDIR_MSB:BIDIR_LSB] = bidirDir;
      end
      RD_AUX_IN: rdata[AUX_W-1:0] = auxIn;
      RD_G0_IN:  rdata[G0_W-1:0]  = g0In;
      RD_G0_OUT: rdata[G0_W-1:0]  = g0Out;
      RD_G0_DIR: rdata[G0_W-1:0]  = g0Dir;
      RD_G1_IN:  rdata[G1_W-1:0]  = g1In;
      RD_G1_OUT: rdata[G1_W-1:0]  = g1Out;
      RD_G1_DIR: rdata[G1_W-1:0]  = g1Dir;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int G0_W   = 8,
  parameter int G1_W   = 24,
  parameter int AUX_W  = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [G0_W-1:0]    g0PadIn,
  output logic [G0_W-1:0]    g0PadOut,
  output logic [G0_W-1:0]    g0PadOe,
  input  logic [G1_W-1:0]    g1PadIn,
  output logic [G1_W-1:0]    g1PadOut,
  output logic [G1_W-1:0]    g1PadOe,
  input  logic [AUX_W-1:0]   auxPadIn,
  output logic [AUX_W-1:0]   auxPadOut,
  output logic [AUX_W-1:0]   auxPadOe,
  input  logic [5:0]         mixBidirIn,
  output logic [5:0]         mixBidirOut,
  output logic [5:0]         mixBidirOe,
  input  logic [23:0]        mixInOnly,
  output logic [23:0]        mixGpo
);
  wrStrobe_t strb;
  rdSel_e    rdSel;

  gpio_sc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr, .busWe, .strb, .rdSel);

  gpio_sc_datapath #(.G0_W(G0_W), .G1_W(G1_W), .AUX_W(AUX_W)) u_dp (
    .clk, .rstN, .strb, .rdSel,
    .wdata(busWdata), .rdata(busRdata),
    .g0PadIn, .g0Out(g0PadOut), .g0Dir(g0PadOe),
    .g1PadIn, .g1Out(g1PadOut), .g1Dir(g1PadOe),
    .auxPadIn, .auxOut(auxPadOut), .auxDir(auxPadOe),
    .bidirPadIn(mixBidirIn), .bidirOut(mixBidirOut), .bidirDir(mixBidirOe),
    .gpiPadIn(mixInOnly), .gpoOut(mixGpo));
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
  parameter int ADDR_W = 8,
  parameter int G0_W   = 8,
  parameter int AUX_W  = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [G0_W-1:0]   g0PadIn,
  input logic [G0_W-1:0]   g0PadOut,
  input logic [G0_W-1:0]   g0PadOe,
  input logic [5:0]        mixBidirOut,
  input logic [5:0]        mixBidirOe,
  input logic [23:0]       mixGpo
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (g0PadOut == '0 && g0PadOe == '0 && mixGpo == '0 && mixBidirOe == '0));

  // R3
  set_bits_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h044)) |=>
      ((g0PadOut & $past(busWdata[G0_W-1:0])) == $past(busWdata[G0_W-1:0])));

  // R3
  set_keeps_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h044)) |=>
      ((g0PadOut & ~$past(busWdata[G0_W-1:0])) == ($past(g0PadOut) & ~$past(busWdata[G0_W-1:0]))));

  // R4
  clear_bits_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h048)) |=> ((g0PadOut & $past(busWdata[G0_W-1:0])) == '0));

  // R7
  bidir_dir_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h010)) |=>
      ((mixBidirOe & $past(busWdata[30:25])) == $past(busWdata[30:25])));

  // R9
  gpo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(mixGpo) && $stable(mixBidirOut)));

  // R10
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && busAddr == ADDR_W'('h040)) |->
      (busRdata[G0_W-1:0] == $past(g0PadIn, 2)));

  // R11
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'('h004) || busAddr == ADDR_W'('h048)) |-> (busRdata == '0));
endmodule

bind gpio_setclr_ctrl gpio_sc_chk #(.ADDR_W(ADDR_W), .G0_W(G0_W), .AUX_W(AUX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .g0PadIn(g0PadIn), .g0PadOut(g0PadOut), .g0PadOe(g0PadOe),
  .mixBidirOut(mixBidirOut), .mixBidirOe(mixBidirOe), .mixGpo(mixGpo));

// File: tb/test_gpio_setclr_ctrl.sv
module test_gpio_setclr_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  g0PadIn = '0, g0PadOut, g0PadOe;
  logic [23:0] g1PadIn = '0, g1PadOut, g1PadOe;
  logic [12:0] auxPadIn = '0, auxPadOut, auxPadOe;
  logic [5:0]  mixBidirIn = '0, mixBidirOut, mixBidirOe;
  logic [23:0] mixInOnly = '0, mixGpo;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  gpio_setclr_ctrl i_gpio_setclr_ctrl (.*);

  typedef struct packed {
    logic [31:0] tag;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{"R3  ", 8'h44, 32'h0000_00A5, 8'h4C, 32'h0000_00A5},
    '{"R3  ", 8'h44, 32'h0000_000F, 8'h4C, 32'h0000_00AF},
    '{"R4  ", 8'h48, 32'h0000_0081, 8'h4C, 32'h0000_002E},
    '{"R5  ", 8'h50, 32'h0000_00F0, 8'h58, 32'h0000_00F0},
    '{"R5  ", 8'h54, 32'h0000_0030, 8'h58, 32'h0000_00C0},
    '{"R2  ", 8'h64, 32'h1234_5678, 8'h6C, 32'h0034_5678},
    '{"R4  ", 8'h68, 32'h0000_0078, 8'h6C, 32'h0034_5600},
    '{"R6  ", 8'h10, 32'h0000_1ABC, 8'h18, 32'h0000_1ABC},
    '{"R7  ", 8'h10, 32'h7E00_0000, 8'h18, 32'h7E00_1ABC},
    '{"R6  ", 8'h14, 32'h0000_0ABC, 8'h18, 32'h7E00_1000},
    '{"R9  ", 8'h04, 32'h4000_0001, 8'h0C, 32'h4000_0001},
    '{"R7  ", 8'h04, 32'h0280_0000, 8'h0C, 32'h4280_0001},
    '{"R4  ", 8'h08, 32'h4000_0001, 8'h0C, 32'h0280_0000},
    '{"R9  ", 8'h04, 32'h8100_0000, 8'h0C, 32'h0280_0000},
    '{"R11 ", 8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0280_0000},
    '{"R11 ", 8'hF0, 32'hFFFF_FFFF, 8'hF0, 32'h0000_0000},
    '{"R11 ", 8'h48, 32'h0000_0000, 8'h44, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  initial begin
    #200000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {g0PadOut, g0PadOe, mixBidirOe, mixBidirOut}, '0);
    check("R1", {8'h0, mixGpo}, '0);
    check("R1", {3'b0, auxPadOe, auxPadOut}, '0);
    busRead(8'h4C, rd); check("R1", rd, '0);

    for (int i = 0; i < NVEC; i++) begin
      busWrite(VECS[i].wa, VECS[i].wd);
      busRead(VECS[i].ra, rd);
      check(string'(VECS[i].tag), rd, VECS[i].exp);
    end

    // pad-side vectors after the table
    check("R3", {24'h0, g0PadOut}, 32'h2E);
    check("R5", {24'h0, g0PadOe}, 32'hC0);
    check("R9", {8'h0, mixGpo}, 32'h80_0000);
    check("R7", {26'h0, mixBidirOut}, 32'h01);
    check("R7", {26'h0, mixBidirOe}, 32'h3F);
    busWrite(8'h20, 32'h0000_1555);
    check("R6", {19'h0, auxPadOut}, 32'h1555);
    busWrite(8'h24, 32'h0000_0005);
    check("R6", {19'h0, auxPadOut}, 32'h1550);

    // R10 synchronizer latency
    @(negedge clk);
    busAddr = 8'h40; g0PadIn = 8'h5A;
    @(posedge clk); #1;
    check("R10", busRdata, 32'h0);
    @(posedge clk); #1;
    check("R10", busRdata, 32'h5A);

    // R8 mixed input mapping
    @(negedge clk);
    mixBidirIn = 6'h3F; mixInOnly = 24'h00_7C00;
    repeat (3) @(negedge clk);
    busRead(8'h00, rd); check("R8", rd, 32'h0100_7C00);
    @(negedge clk);
    mixBidirIn = 6'h00; mixInOnly = 24'hFF_FFFF;
    repeat (3) @(negedge clk);
    busRead(8'h00, rd); check("R8", rd, 32'h00FF_83FF);
    @(negedge clk);
    mixBidirIn = 6'h21; mixInOnly = 24'h0;
    repeat (3) @(negedge clk);
    busRead(8'h00, rd); check("R8", rd, 32'h0100_0400);
    busRead(8'h0C, rd); check("R9", rd, 32'h0280_0000);

    // R6 / R2 input registers
    @(negedge clk);
    auxPadIn = 13'h1234; g1PadIn = 24'hABCDEF;
    repeat (3) @(negedge clk);
    busRead(8'h1C, rd); check("R6", rd, 32'h1234);
    busRead(8'h60, rd); check("R2", rd, 32'h00AB_CDEF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule